// File: doc/BRIEF.md
# Single-Bus Byte Datapath

This block is the storage and transfer half of a small accumulator-style processor. One 8-bit bus connects two operand registers, an address register, an instruction register, an output register, a program counter, an adder and a 16-byte memory. A separate sequencer supplies the control word on every clock. The control word is a set of sink strobes, a set of source enables and a counter-enable. In each cycle one source places a value on the bus. Every sink whose strobe is set captures that value at the next rising clock edge.

The instruction register drives only its operand nibble onto the bus. The memory is addressed by the low address bits of the address register. The adder result is itself a bus source, so an addition is a single transfer from the adder into any sink. Loading the output register produces a one-cycle valid pulse. A preload port fills the memory while the core is held in reset. The bus value is brought out so that any register can be observed by enabling it as the source.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst_n` is low and after it is released, the operand, address, instruction, output and counter registers read zero, and `out_vld` is low.
- R2: `drive_sel` bit positions select the bus source: 0 operand A, 1 operand B, 2 instruction register, 3 adder, 4 counter, 5 memory. At most one bit may be set in a cycle. With no bit set, `bus_val` is zero. `bus_val` follows `drive_sel` combinationally, so a value can be moved from a source to a sink in the same cycle.
- R3: `load_sel` bit positions select the sinks: 0 operand A, 1 operand B, 2 address register, 3 instruction register, 4 output register, 5 counter, 6 memory. Each register with its bit set captures `bus_val` on the rising edge. Each register with its bit clear keeps its value.
- R4: When the instruction register is the source, the bus carries its low 4 bits, and bits 7:4 are zero.
- R5: When the adder is the source, the bus carries A plus B modulo 256, so 144 + 233 gives 121.
- R6: The memory holds 16 bytes addressed by bits 3:0 of the address register. As a source it drives the addressed byte. With `load_sel` bit 6 set, it writes `bus_val` into that byte on the rising edge.
- R7: The counter loads `bus_val` when `load_sel` bit 5 is set. Otherwise, when `cnt_en` is set, it adds 1 and wraps from 255 to 0. Loading takes priority over counting.
- R8: `out_val` shows the output register. `out_vld` is high for exactly the one cycle that follows each edge at which the output register loaded.
- R9: With `pre_we` high, `pre_data` is written to memory byte `pre_addr` on the rising edge, including while `rst_n` is low. A preload takes priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_sel | input | 7 | Sink strobes, one per sink |
| drive_sel | input | 6 | Source enables, at most one set |
| cnt_en | input | 1 | Counter increment |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | 4 | Memory preload address |
| pre_data | input | 8 | Memory preload data |
| bus_val | output | 8 | Current bus value |
| out_val | output | 8 | Output register value |
| out_vld | output | 1 | One-cycle pulse after each output load |

## Verification
The operations that coincide most often are a bus load of the counter and its increment, and a memory read whose byte is written back through the bus in the same cycle. The counter collision is provoked by a long run of control words with random sink masks and a random `cnt_en`, plus a directed wrap from 255. The read-and-write case comes up in the same run whenever the memory is both source and sink. A behavioural model recomputes the bus and every register from the requirements each cycle. The bus and the output port are compared with the model before each edge, so a wrong priority or a wrong address shows up as a miscompare on the next read.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   // sink strobe positions (load_sel)
   localparam int SNK_A   = 0;
   localparam int SNK_B   = 1;
   localparam int SNK_MAR = 2;
   localparam int SNK_IR  = 3;
   localparam int SNK_OUT = 4;
   localparam int SNK_PC  = 5;
   localparam int SNK_RAM = 6;
   localparam int N_SNK   = 7;
   // plain registers occupy sink positions 0 .. N_GREG-1
   localparam int N_GREG  = 5;

   // source enable positions (drive_sel)
   localparam int SRC_A   = 0;
   localparam int SRC_B   = 1;
   localparam int SRC_IR  = 2;
   localparam int SRC_SUM = 3;
   localparam int SRC_PC  = 4;
   localparam int SRC_RAM = 5;
   localparam int N_SRC   = 6;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   // R3: an unselected register holds its value
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
endmodule

// File: rtl/sbus_pc.sv
module sbus_pc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= d;
      else if (inc) q <= q + W'(1);
   end

   // R7: count step with wrap when not loading
   p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld) |=> (q == $past(q) + W'(1)));
endmodule

// File: rtl/sbus_ram.sv
module sbus_ram #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          pre_we,
   input  logic [AW-1:0] pre_addr,
   input  logic [W-1:0]  pre_data,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rd
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (pre_we)  mem[pre_addr] <= pre_data;
      else if (we) mem[addr]     <= wd;
   end

   assign rd = mem[addr];
endmodule

// File: rtl/sbus_mux.sv
module sbus_mux #(
   parameter int W = 8,
   parameter int N = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] src,
   output logic [W-1:0]        bus
);
   logic [N-1:0][W-1:0] gated;

   for (genvar s = 0; s < N; s++) begin : g_gate
      assign gated[s] = src[s] & {W{sel[s]}};
   end

   always_comb begin
      bus = '0;
      for (int s = 0; s < N; s++) bus = bus | gated[s];
   end

   // R2: never more than one driver
   p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) <= 1);
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int RAM_DEPTH = 16,
   localparam int AW       = $clog2(RAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SNK-1:0]  load_sel,
   input  logic [N_SRC-1:0]  drive_sel,
   input  logic              cnt_en,
   input  logic              pre_we,
   input  logic [AW-1:0]     pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   output logic [DATA_W-1:0] bus_val,
   output logic [DATA_W-1:0] out_val,
   output logic              out_vld
);
   if (AW > DATA_W || AW < 1) begin : g_bad_aw
      $error("address width must fit the data width");
   end
   if ((1 << AW) != RAM_DEPTH) begin : g_bad_depth
      $error("memory depth must be a power of two");
   end

   logic [N_GREG-1:0][DATA_W-1:0] greg_q;
   logic [N_SRC-1:0][DATA_W-1:0]  src;
   logic [DATA_W-1:0]             sum, pc_q, ram_rd, bus;

   for (genvar g = 0; g < N_GREG; g++) begin : g_reg
      sbus_reg #(.W(DATA_W)) u_reg (
         .clk(clk), .rst_n(rst_n), .ld(load_sel[g]), .d(bus), .q(greg_q[g]));
   end

   sbus_pc #(.W(DATA_W)) u_pc (
      .clk(clk), .rst_n(rst_n), .ld(load_sel[SNK_PC]), .inc(cnt_en),
      .d(bus), .q(pc_q));

   sbus_ram #(.W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
      .we(load_sel[SNK_RAM] & rst_n), .addr(greg_q[SNK_MAR][AW-1:0]),
      .wd(bus), .rd(ram_rd));

   assign sum = greg_q[SNK_A] + greg_q[SNK_B];

   assign src[SRC_A]   = greg_q[SNK_A];
   assign src[SRC_B]   = greg_q[SNK_B];
   assign src[SRC_IR]  = {{(DATA_W-AW){1'b0}}, greg_q[SNK_IR][AW-1:0]};
   assign src[SRC_SUM] = sum;
   assign src[SRC_PC]  = pc_q;
   assign src[SRC_RAM] = ram_rd;

   sbus_mux #(.W(DATA_W), .N(N_SRC)) u_mux (
      .clk(clk), .rst_n(rst_n), .sel(drive_sel), .src(src), .bus(bus));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= load_sel[SNK_OUT];
   end

   assign bus_val = bus;
   assign out_val = greg_q[SNK_OUT];

   // R4: operand nibble only
   p_ir_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drive_sel[SRC_IR] |-> (bus_val[DATA_W-1:AW] == '0));
   // R5: adder source wraps
   p_sum_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_sel[SRC_SUM] |-> (bus_val == DATA_W'(greg_q[SNK_A] + greg_q[SNK_B])));
   // R8: valid follows an output load
   p_out_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_sel[SNK_OUT] |=> (out_vld && out_val == $past(bus_val)));
endmodule

// File: tb/sbus_datapath_tb_top.sv
module sbus_datapath_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] load_sel = '0;
   logic [5:0] drive_sel = '0;
   logic       cnt_en = 1'b0;
   logic       pre_we = 1'b0;
   logic [3:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic [7:0] bus_val, out_val;
   logic       out_vld;

   always #4 clk = ~clk;

   sbus_datapath dut_i (
      .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .drive_sel(drive_sel),
      .cnt_en(cnt_en), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .bus_val(bus_val), .out_val(out_val),
      .out_vld(out_vld));

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;

   // behavioural reference state
   int ma, mb, mmar, mir, mout, mpc;
   int mram [16];
   bit mvld;

   function automatic int exp_bus();
      case (drive_sel)
         6'b000001: return ma;
         6'b000010: return mb;
         6'b000100: return mir & 15;
         6'b001000: return (ma + mb) & 255;
         6'b010000: return mpc;
         6'b100000: return mram[mmar & 15];
         default:   return 0;
      endcase
   endfunction

   function automatic string bus_tag();
      case (drive_sel)
         6'b000100: return "R4";
         6'b001000: return "R5";
         6'b010000: return "R7";
         6'b100000: return "R6";
         6'b000000: return "R2";
         default:   return "R3";
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one cycle: apply, compare before the edge, then advance the model
   task automatic step(input logic [6:0] ld, input logic [5:0] dr,
                       input logic ce, input string tag);
      int nb;
      @(negedge clk);
      load_sel = ld; drive_sel = dr; cnt_en = ce;
      #1;
      check("R8 out_val", int'(out_val), mout);
      check("R8 out_vld", int'(out_vld), int'(mvld));
      check(tag == "" ? bus_tag() : tag, int'(bus_val), exp_bus());
      nb = exp_bus();
      @(posedge clk);
      if (pre_we) mram[pre_addr] = pre_data;
      if (rst_n) begin
         if (ld[6] && !pre_we) mram[mmar & 15] = nb;
         if (ld[0]) ma = nb;
         if (ld[1]) mb = nb;
         if (ld[2]) mmar = nb;
         if (ld[3]) mir = nb;
         if (ld[4]) mout = nb;
         if (ld[5]) mpc = nb;
         else if (ce) mpc = (mpc + 1) & 255;
         mvld = ld[4];
      end
   endtask

   initial begin
      ma = 0; mb = 0; mmar = 0; mir = 0; mout = 0; mpc = 0; mvld = 0;
      for (int i = 0; i < 16; i++) mram[i] = 0;
      // R9: preload during reset, loads must be ignored (R1)
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         pre_we = 1'b1; pre_addr = 4'(i);
         case (i)
            0: pre_data = 8'h0E;
            1: pre_data = 8'h0F;
            2: pre_data = 8'hFF;
            14: pre_data = 8'd144;
            15: pre_data = 8'd233;
            default: pre_data = 8'(i * 37 + 5);
         endcase
         load_sel = 7'h3F;
         #1;
         check("R1 out_vld in reset", int'(out_vld), 0);
         @(posedge clk);
         mram[i] = int'(pre_data);
      end
      @(negedge clk);
      pre_we = 1'b0; load_sel = '0;
      rst_n = 1'b1;
      // R1: every register reads zero after reset
      step(7'h00, 6'b000001, 1'b0, "R1 A");
      step(7'h00, 6'b000010, 1'b0, "R1 B");
      step(7'h00, 6'b000100, 1'b0, "R1 IR");
      step(7'h00, 6'b010000, 1'b0, "R1 PC");
      step(7'h00, 6'b000000, 1'b0, "R2 idle");
      // R9/R6: fetch, operand fetch, add with wrap
      step(7'b0000100, 6'b010000, 1'b0, "R7 pc->mar");
      step(7'b0001000, 6'b100000, 1'b1, "R9 ram->ir");
      step(7'b0000100, 6'b000100, 1'b0, "R4 ir->mar");
      step(7'b0000001, 6'b100000, 1'b0, "R6 ram->a");
      step(7'b0000100, 6'b010000, 1'b0, "R7 pc->mar");
      step(7'b0001000, 6'b100000, 1'b1, "R9 ram->ir");
      step(7'b0000100, 6'b000100, 1'b0, "R4 ir->mar");
      step(7'b0000010, 6'b100000, 1'b0, "R6 ram->b");
      step(7'b1010000, 6'b001000, 1'b0, "R5 144+233");
      step(7'b0000000, 6'b100000, 1'b0, "R6 written sum");
      step(7'b0000000, 6'b000000, 1'b0, "R8 pulse end");
      // R7: load 255, count wraps, load beats count
      step(7'b0000100, 6'b010000, 1'b0, "R7 pc->mar");
      step(7'b0100000, 6'b100000, 1'b1, "R7 load wins");
      step(7'b0000000, 6'b010000, 1'b1, "R7 at 255");
      step(7'b0000000, 6'b010000, 1'b0, "R7 wrapped");
      // R9: preload beats bus write
      pre_we = 1'b1; pre_addr = 4'd3; pre_data = 8'h5A;
      step(7'b1000000, 6'b000001, 1'b0, "R9 preload prio");
      pre_we = 1'b0;
      step(7'b0000100, 6'b000000, 1'b0, "R2 mar<-0");
      step(7'b0000000, 6'b000000, 1'b0, "R2 idle");
      // mixed traffic, one source at most
      for (int k = 0; k < 3000; k++) begin
         int s;
         logic [5:0] dr;
         s = int'($urandom % 8);
         dr = (s < 6) ? 6'(1 << s) : 6'b0;
         step(7'($urandom), dr, 1'($urandom), "");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule